// File: doc/BRIEF.md
# Single-Channel Bus-Hold DMA Engine

This block moves a block of words between one peripheral and memory on a system bus that it shares with a CPU. Before a run, software loads a start address, a word count and a direction through a small configuration port. The count is given as the negative of the block length in two's complement, and it counts upward. Software then sets the start bit. Each time the device shows a word ready, or shows that it can accept a word, the block sets a request flag and raises `hold`. When the CPU answers with `hlda`, the block makes one single-cycle bus access. It moves the word through a one-word buffer register, pulses `dev_ack` to the device and advances both counters. It then drops `hold` and waits for `hlda` to fall before it asks for the bus again.

When the count carries out of its top bit, the channel disables itself and raises a sticky interrupt. A configuration write clears the interrupt. A new run cannot start while the interrupt is pending.

Top module: `dma_hold_link`

## Requirements
- R1: After reset, `hold`, `bus_rd`, `bus_wr`, `dev_ack` and `irq` are all low, and the channel is disabled.
- R2: `hold` rises on the clock edge at which the enabled, idle channel samples `dev_rdy` high, and it stays high until the word's bus access has completed.
- R3: A bus strobe (`bus_rd` or `bus_wr`) is issued only on the edge after `hlda` is sampled high while `hold` is high.
- R4: Direction 0 (device to memory) behaves as follows.
  - The device word is captured into the buffer on the grant edge.
  - The word is written with `bus_wr` in the same cycle as `dev_ack`.
  - Successive words go to consecutive addresses starting at the loaded address.
- R5: Direction 1 (memory to device) behaves as follows.
  - `bus_rd` is issued, and `bus_rdata` is taken one cycle after the strobe.
  - The word appears on `dev_rdata` while `dev_ack` pulses, two cycles after the strobe cycle.
  - Addresses increment from the loaded address and wrap modulo 2^AW.
- R6: Each grant moves exactly one word. `hold` falls after the access, and it rises again only if `hlda` was sampled low on the edge before.
- R7: Loading the count register with 2^CW − N gives exactly N bus accesses. `irq` rises two cycles after the last strobe cycle, the channel disables itself, and it makes no further accesses even while `dev_rdy` stays high. N = 1 corresponds to a loaded count of all ones.
- R8: `irq` is a sticky level. It stays high until a control write (select 2) with bit 2 set. While `irq` is high, a control write with the start bit (bit 0) set has no effect.
- R9: While the channel is enabled, all configuration writes are ignored. This covers the address (select 0), the count (select 1) and the control register (select 2).
- R10: `dev_ack` is a one-cycle pulse. It clears the request flag.
- R11: `bus_rd` and `bus_wr` are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control (bit0 start, bit1 direction, bit2 clear irq) |
| cfg_wdata | input | AW | Configuration write data |
| dev_rdy | input | 1 | Device has a word ready (dir 0) or can accept one (dir 1) |
| dev_wdata | input | DW | Word offered by the device |
| dev_ack | output | 1 | One-cycle acknowledge to the device |
| dev_rdata | output | DW | Word delivered to the device (buffer register) |
| hold | output | 1 | Bus request to the CPU |
| hlda | input | 1 | Bus grant from the CPU |
| bus_rd | output | 1 | Single-cycle memory read strobe |
| bus_wr | output | 1 | Single-cycle memory write strobe |
| bus_addr | output | AW | Memory address |
| bus_wdata | output | DW | Memory write data (buffer register) |
| bus_rdata | input | DW | Memory read data, valid one cycle after `bus_rd` |
| irq | output | 1 | Sticky end-of-block interrupt |

## Verification
`hold` is due one cycle after the idle channel samples `dev_rdy`. A strobe is due one cycle after `hlda` is sampled, and read data is due one cycle after `bus_rd`. For reads, `dev_ack` with the word is due two cycles after the strobe cycle. `irq` is due two cycles after the final strobe cycle. The bench's monitor samples a quarter period after each rising edge, and it keeps one-sample and two-sample histories of the strobes. Each result is compared against the history sample where that latency places its cause, and the scoreboard pops one expected address/word pair each time a strobe or acknowledge appears.

// File: rtl/dma_hold_pkg.sv
package dma_hold_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_HOLD,
    S_BUS,
    S_WAIT,
    S_REL
  } dma_st_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CTRL_START = 0;
  localparam int CTRL_DIR   = 1;
  localparam int CTRL_CLR   = 2;
endpackage

// File: rtl/dma_hold_regs.sv
module dma_hold_regs
  import dma_hold_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          adv_i,
  output logic          en_o,
  output logic          dir_o,
  output logic          irq_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          cnt_carry;
  logic          en_q, dir_q, irq_q;
  logic          clr_wr;

  assign {cnt_carry, cnt_nxt} = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign clr_wr = cfg_wr && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else if (en_q) begin
      if (adv_i) begin
        addr_q <= addr_q + 1'b1;
        cnt_q  <= cnt_nxt;
        if (cnt_carry) begin
          en_q  <= 1'b0;
          irq_q <= 1'b1;
        end
      end
    end else if (cfg_wr) begin
      case (cfg_sel)
        SEL_ADDR: addr_q <= cfg_wdata;
        SEL_CNT:  cnt_q  <= cfg_wdata[CW-1:0];
        SEL_CTRL: begin
          if (cfg_wdata[CTRL_CLR]) irq_q <= 1'b0;
          if (cfg_wdata[CTRL_START] && !irq_q) begin
            en_q  <= 1'b1;
            dir_q <= cfg_wdata[CTRL_DIR];
          end
        end
        default: ;
      endcase
    end
  end

  assign en_o   = en_q;
  assign dir_o  = dir_q;
  assign irq_o  = irq_q;
  assign addr_o = addr_q;

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr_wr) |=> irq_q);
  assert_no_start_pending_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> !$past(irq_q));
  assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (en_q && !adv_i) |=> $stable(addr_q));
  assert_irq_on_advance_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(adv_i));
endmodule

// File: rtl/dma_hold_seq.sv
module dma_hold_seq
  import dma_hold_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          dir_i,
  input  logic [AW-1:0] addr_i,
  input  logic          dev_rdy,
  input  logic [DW-1:0] dev_wdata,
  input  logic          hlda,
  input  logic [DW-1:0] bus_rdata,
  output logic          hold,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] xfer_buf,
  output logic          dev_ack,
  output logic          adv_o
);
  dma_st_t st_q;
  logic    req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      req_q    <= 1'b0;
      hold     <= 1'b0;
      bus_rd   <= 1'b0;
      bus_wr   <= 1'b0;
      dev_ack  <= 1'b0;
      bus_addr <= '0;
      xfer_buf <= '0;
    end else begin
      bus_rd  <= 1'b0;
      bus_wr  <= 1'b0;
      dev_ack <= 1'b0;
      case (st_q)
        S_IDLE: if (en_i && dev_rdy && !req_q) begin
          req_q <= 1'b1;
          hold  <= 1'b1;
          st_q  <= S_HOLD;
        end
        S_HOLD: if (hlda) begin
          bus_addr <= addr_i;
          st_q     <= S_BUS;
          if (!dir_i) begin
            xfer_buf <= dev_wdata;
            bus_wr   <= 1'b1;
            dev_ack  <= 1'b1;
            req_q    <= 1'b0;
          end else begin
            bus_rd <= 1'b1;
          end
        end
        S_BUS: st_q <= S_WAIT;
        S_WAIT: begin
          hold <= 1'b0;
          st_q <= S_REL;
          if (dir_i) begin
            xfer_buf <= bus_rdata;
            dev_ack  <= 1'b1;
            req_q    <= 1'b0;
          end
        end
        S_REL: if (!hlda) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign adv_o = (st_q == S_WAIT);

  assert_strobe_granted_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> (hold && hlda));
  assert_hold_after_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> !$past(hlda));
  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    dev_ack |=> (!dev_ack && !req_q));
  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |=> !(bus_rd || bus_wr));
endmodule

// File: rtl/dma_hold_link.sv
module dma_hold_link
  import dma_hold_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          dev_rdy,
  input  logic [DW-1:0] dev_wdata,
  output logic          dev_ack,
  output logic [DW-1:0] dev_rdata,
  output logic          hold,
  input  logic          hlda,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic          en_w, dir_w, adv_w;
  logic [AW-1:0] addr_w;
  logic [DW-1:0] buf_w;

  dma_hold_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .adv_i(adv_w), .en_o(en_w), .dir_o(dir_w),
    .irq_o(irq), .addr_o(addr_w)
  );

  dma_hold_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .en_i(en_w), .dir_i(dir_w), .addr_i(addr_w),
    .dev_rdy(dev_rdy), .dev_wdata(dev_wdata), .hlda(hlda),
    .bus_rdata(bus_rdata), .hold(hold), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .xfer_buf(buf_w), .dev_ack(dev_ack), .adv_o(adv_w)
  );

  assign bus_wdata = buf_w;
  assign dev_rdata = buf_w;

  initial begin
    assert_cfg_width_R9: assert (CW <= AW && AW >= 3);
  end
endmodule

// File: tb/dma_hold_link_bench.sv
module dma_hold_link_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          dev_rdy = 1'b0;
  logic [DW-1:0] dev_wdata = '0;
  logic          dev_ack, hold, bus_rd, bus_wr, irq;
  logic [DW-1:0] dev_rdata, bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic [AW-1:0] bus_addr;
  logic          hlda = 1'b0;

  dma_hold_link #(.AW(AW), .DW(DW), .CW(CW)) u_dma_hold_link (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dev_rdy(dev_rdy), .dev_wdata(dev_wdata),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata), .hold(hold), .hlda(hlda),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int strobe_cnt = 0;
  logic [DW-1:0] mem [0:(1<<AW)-1];

  logic [AW-1:0] exp_wa[$];
  logic [DW-1:0] exp_wd[$];
  logic [DW-1:0] exp_rd[$];
  logic          out_mode = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int idx);
    return DW'(16'hA53C ^ (idx * 16'h0139));
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (bus_wr) mem[bus_addr] <= bus_wdata;
    if (bus_rd) bus_rdata <= mem[bus_addr];
  end

  // CPU grant model
  int gdly = 1;
  int gcnt = 0;
  always @(negedge clk) begin
    if (hold) begin
      if (gcnt >= gdly) hlda <= 1'b1;
      else gcnt++;
    end else begin
      gcnt = 0;
      hlda <= 1'b0;
    end
  end

  // device model
  bit dev_on = 0;
  int dev_gap = 0;
  int gap_cnt = 0;
  int dev_idx = 0;
  always @(negedge clk) begin
    if (dev_ack) begin
      dev_rdy <= 1'b0;
      gap_cnt = dev_gap;
      if (!out_mode) dev_idx++;
    end else if (dev_on && !dev_rdy) begin
      if (gap_cnt == 0) begin
        dev_rdy <= 1'b1;
        dev_wdata <= pat(dev_idx);
      end else gap_cnt--;
    end
  end

  // monitor / scoreboard
  logic st1 = 1'b0, st2 = 1'b0, rd1 = 1'b0, rd2 = 1'b0;
  logic pv_hold = 1'b0, pv_irq = 1'b0, pv_ack = 1'b0, pv_str = 1'b0;
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!rst) begin
      if (bus_rd || bus_wr) begin
        strobe_cnt++;
        if (!pv_str) chk(hlda && hold, "R3 strobe without grant", int'(hlda), 1);
        chk(!pv_str, "R11 strobe longer than one cycle", int'(pv_str), 0);
        chk(!(bus_rd && bus_wr), "R11 both strobes", int'(bus_rd & bus_wr), 0);
      end
      if (hold && !pv_hold)
        chk(dev_rdy, "R2 hold without device request", int'(dev_rdy), 1);
      if (bus_wr) begin
        if (exp_wa.size() == 0) chk(0, "R4 unexpected write", int'(bus_addr), 0);
        else begin
          logic [AW-1:0] ea;
          logic [DW-1:0] ed;
          ea = exp_wa.pop_front();
          ed = exp_wd.pop_front();
          chk(bus_addr == ea, "R4 write address", int'(bus_addr), int'(ea));
          chk(bus_wdata == ed, "R4 write data", int'(bus_wdata), int'(ed));
          chk(dev_ack, "R4 ack with write", int'(dev_ack), 1);
        end
      end
      if (dev_ack && out_mode) begin
        chk(rd2, "R5 ack two cycles after read", int'(rd2), 1);
        if (exp_rd.size() == 0) chk(0, "R5 unexpected delivery", int'(dev_rdata), 0);
        else begin
          logic [DW-1:0] er;
          er = exp_rd.pop_front();
          chk(dev_rdata == er, "R5 delivered word", int'(dev_rdata), int'(er));
        end
      end
      if (dev_ack) chk(!pv_ack, "R10 ack longer than one cycle", int'(pv_ack), 0);
      if (irq && !pv_irq) chk(st2 && !st1, "R7 irq latency after last strobe", int'(st2), 1);
    end
    st2 = st1;
    st1 = bus_rd || bus_wr;
    rd2 = rd1;
    rd1 = bus_rd;
    pv_str = st1;
    pv_hold = hold;
    pv_irq = irq;
    pv_ack = dev_ack;
  end

  task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_sel = sel;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic finish_run(input int n, input int s0, input string req);
    wait_irq();
    repeat (20) @(negedge clk);
    chk(strobe_cnt - s0 == n, req, strobe_cnt - s0, n);
    chk(irq == 1'b1, "R7 irq after block", int'(irq), 1);
    chk(hold == 1'b0, "R7 hold released after block", int'(hold), 0);
    chk(exp_wa.size() == 0 && exp_rd.size() == 0, "R7 scoreboard drained",
        exp_wa.size() + exp_rd.size(), 0);
    dev_on = 0;
    @(negedge clk);
    dev_rdy = 1'b0;
  endtask

  task automatic run_in(input logic [AW-1:0] a, input int n, input int gap, input bit poke);
    int s0;
    out_mode = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp_wa.push_back(AW'(a + AW'(i)));
      exp_wd.push_back(pat(dev_idx + i));
    end
    cfg(SEL_ADDR_C, a);
    cfg(SEL_CNT_C, AW'(CW'(0) - CW'(n)));
    s0 = strobe_cnt;
    dev_gap = gap;
    cfg(SEL_CTRL_C, 8'h01);
    dev_on = 1;
    if (poke) begin
      while (strobe_cnt == s0) @(negedge clk);
      cfg(SEL_ADDR_C, 8'hF0);      // R9: ignored while enabled
      cfg(SEL_CNT_C, 8'hFF);       // R9: ignored while enabled
      cfg(SEL_CTRL_C, 8'h06);      // R9: direction/clear ignored while enabled
    end
    finish_run(n, s0, "R7 input word count");
  endtask

  task automatic run_out(input logic [AW-1:0] a, input int n, input int gap);
    int s0;
    out_mode = 1'b1;
    for (int i = 0; i < n; i++) begin
      mem[AW'(a + AW'(i))] = pat(100 + i);
      exp_rd.push_back(pat(100 + i));
    end
    cfg(SEL_ADDR_C, a);
    cfg(SEL_CNT_C, AW'(CW'(0) - CW'(n)));
    s0 = strobe_cnt;
    dev_gap = gap;
    cfg(SEL_CTRL_C, 8'h03);
    dev_on = 1;
    finish_run(n, s0, "R7 output word count");
  endtask

  localparam logic [1:0] SEL_ADDR_C = 2'd0;
  localparam logic [1:0] SEL_CNT_C  = 2'd1;
  localparam logic [1:0] SEL_CTRL_C = 2'd2;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog expired: actual=%0d expected=<50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!hold && !bus_rd && !bus_wr && !dev_ack && !irq, "R1 reset outputs",
        {hold, bus_rd, bus_wr, dev_ack, irq}, 0);
    dev_rdy = 1'b1;
    repeat (4) @(negedge clk);
    chk(!hold, "R1 disabled channel ignores request", int'(hold), 0);
    dev_rdy = 1'b0;

    gdly = 1;
    run_in(8'h10, 5, 0, 0);

    // R8 start ignored while irq pending
    begin
      int s0;
      s0 = strobe_cnt;
      dev_on = 1;
      cfg(SEL_CTRL_C, 8'h01);
      repeat (12) @(negedge clk);
      chk(strobe_cnt == s0, "R8 start blocked while irq pending", strobe_cnt - s0, 0);
      chk(irq, "R8 irq sticky", int'(irq), 1);
      dev_on = 0;
      @(negedge clk);
      dev_rdy = 1'b0;
    end
    cfg(SEL_CTRL_C, 8'h04);
    @(negedge clk);
    chk(!irq, "R8 irq cleared by write", int'(irq), 0);

    gdly = 3;
    run_out(8'h40, 4, 2);
    cfg(SEL_CTRL_C, 8'h04);

    gdly = 0;
    run_in(8'h20, 1, 1, 0);      // R7 single word, count all ones
    cfg(SEL_CTRL_C, 8'h04);

    gdly = 2;
    run_in(8'h80, 4, 0, 1);      // R9 mid-run writes ignored
    cfg(SEL_CTRL_C, 8'h04);

    gdly = 1;
    run_out(8'hFE, 3, 0);        // R5 address wrap
    cfg(SEL_CTRL_C, 8'h04);
    @(negedge clk);
    chk(!irq && !hold, "R6 idle after final clear", {irq, hold}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule